// File: doc/BRIEF.md
# Video-mode line and frame timing engine

This block paces a display serial link running in video mode. Horizontal time is counted in lane-byte clock cycles. The sync width, back porch and whole line length are programmed directly in those cycles. The visible width is programmed in pixels and converted to byte cycles from the lane count, with 24-bit colour (3 bytes per pixel). Whatever remains of the line after sync, back porch and active time is the front porch. Vertical time is counted in whole lines, in the order sync, back porch, active, front porch, after which the next frame begins.

Every cycle the block reports the horizontal and vertical phase, sync levels with programmable polarity, a data-enable, and single-cycle markers for the start and end of each sync. A packet builder downstream uses these to decide what to send. The video mode type chooses which markers appear: sync-pulse and burst modes mark both edges of each sync, while sync-event mode marks only the start. The configuration inputs are sampled into a shadow copy during reset and again on the last cycle of every frame. A change therefore never tears the frame in progress.

Top module: `dsi_vid_timer`

## Requirements
- R1: While reset is high, de_o and all markers are 0, and hsync_o and vsync_o equal cfg_pol bit 2 and bit 1. In the first cycle after reset is released, frame_start_o and hss_o are 1.
- R2: A line lasts cfg_hline cycles, or 1 cycle when cfg_hline is 0. hss_o pulses exactly once per line, on its first cycle.
- R3: Within a line the horizontal phase (0 sync, 1 back porch, 2 active, 3 front porch) runs cfg_hsa cycles of sync, then cfg_hbp cycles of back porch, then the active time, then front porch until the line ends.
- R4: The active time in byte cycles is ceil(3 × cfg_pkt_pix / N), where N = cfg_lanes + 1 (cfg_lanes 0..3 selects 1..4 lanes).
- R5: A frame is cfg_vsa + cfg_vbp + cfg_vact + cfg_vfp lines in the order sync, back porch, active, front porch, with the same phase codes. The vertical sync field is 4 bits wide (up to 15 lines). vss_o pulses on the first cycle of the frame when cfg_vsa is not 0.
- R6: de_o is 1 only when both horizontal and vertical phases are active, so a frame carries cfg_vact × active-time enabled cycles.
- R7: A cfg_pol bit 2 of 1 makes hsync_o low during horizontal sync; bit 1 does the same for vsync_o and vertical sync. Otherwise both are active high.
- R8: cfg_mode 0 selects sync pulses, 1 selects sync events and 2 or 3 selects burst. hse_o (first cycle after a nonzero horizontal sync) and vse_o (first cycle of the first line after a nonzero vertical sync) appear in modes 0, 2 and 3 and never in mode 1.
- R9: Configuration changes made during a frame take effect only from the start of the next frame.
- R10: If sync, back porch and active time together exceed the line, the active time is cut off at the line end and there is no front porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane-byte clock |
| rst | input | 1 | Synchronous active-high reset; also loads the configuration |
| cfg_hsa | input | HW | Horizontal sync width in byte cycles |
| cfg_hbp | input | HW | Horizontal back porch in byte cycles |
| cfg_hline | input | HW | Total line length in byte cycles |
| cfg_vsa | input | SW | Vertical sync lines |
| cfg_vbp | input | VW | Vertical back porch lines |
| cfg_vact | input | VW | Active lines |
| cfg_vfp | input | VW | Vertical front porch lines |
| cfg_pkt_pix | input | PW | Active width in pixels |
| cfg_lanes | input | 2 | Lane count minus one |
| cfg_pol | input | 3 | Bit 2 hsync active low, bit 1 vsync active low |
| cfg_mode | input | 2 | Video mode type |
| h_phase | output | 2 | Horizontal phase code |
| v_phase | output | 2 | Vertical phase code |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| de_o | output | 1 | Data enable |
| hss_o | output | 1 | Horizontal sync start marker |
| hse_o | output | 1 | Horizontal sync end marker |
| vss_o | output | 1 | Vertical sync start marker |
| vse_o | output | 1 | Vertical sync end marker |
| frame_start_o | output | 1 | First cycle of a frame |

## Verification
A wrong horizontal counter or boundary shows up within one line as a shifted first data-enable cycle or a wrong count of sync cycles. A wrong line or frame counter shows up within one frame as a wrong frame length, data-enable total or vertical marker count. A shadow copy that loads at the wrong time shows as a frame whose length follows a configuration written part way through it. A mode or polarity error appears at the first sync of the frame.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    VM_PULSE  = 2'd0,
    VM_EVENT  = 2'd1,
    VM_BURST  = 2'd2,
    VM_BURST2 = 2'd3
  } vmode_e;

  localparam int BYTES_PER_PIX = 3;
endpackage

// File: rtl/dvt_cfg_shadow.sv
module dvt_cfg_shadow
  import dvt_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 12,
  parameter int SW = 4,
  localparam int BW  = ((HW > PW) ? HW : PW) + 3,
  localparam int VBW = VW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [HW-1:0]  cfg_hsa,
  input  logic [HW-1:0]  cfg_hbp,
  input  logic [HW-1:0]  cfg_hline,
  input  logic [SW-1:0]  cfg_vsa,
  input  logic [VW-1:0]  cfg_vbp,
  input  logic [VW-1:0]  cfg_vact,
  input  logic [VW-1:0]  cfg_vfp,
  input  logic [PW-1:0]  cfg_pkt_pix,
  input  logic [1:0]     cfg_lanes,
  input  logic [2:0]     cfg_pol,
  input  logic [1:0]     cfg_mode,
  output logic [HW-1:0]  hline_o,
  output logic [BW-1:0]  hb1_o,
  output logic [BW-1:0]  hb2_o,
  output logic [BW-1:0]  hb3_o,
  output logic [VBW-1:0] vb1_o,
  output logic [VBW-1:0] vb2_o,
  output logic [VBW-1:0] vb3_o,
  output logic [VBW-1:0] vtot_o,
  output logic           hs_low_o,
  output logic           vs_low_o,
  output vmode_e         mode_o
);
  localparam int AW = PW + 2;

  logic [AW-1:0] bytes_w;
  logic [AW-1:0] act_w;
  logic [BW-1:0] nb1, nb2, nb3;
  logic [VBW-1:0] nv1, nv2, nv3, nvt;

  // active byte cycles: ceil(3*pix / lanes); only 1, 2, 3 and 4 lanes exist
  always_comb begin
    bytes_w = AW'(cfg_pkt_pix) + (AW'(cfg_pkt_pix) << 1);
    unique case (cfg_lanes)
      2'd0:    act_w = bytes_w;
      2'd1:    act_w = (bytes_w + AW'(1)) >> 1;
      2'd2:    act_w = AW'(cfg_pkt_pix);
      default: act_w = (bytes_w + AW'(3)) >> 2;
    endcase
    nb1 = BW'(cfg_hsa);
    nb2 = nb1 + BW'(cfg_hbp);
    nb3 = nb2 + BW'(act_w);
    nv1 = VBW'(cfg_vsa);
    nv2 = nv1 + VBW'(cfg_vbp);
    nv3 = nv2 + VBW'(cfg_vact);
    nvt = nv3 + VBW'(cfg_vfp);
  end

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      hline_o  <= cfg_hline;
      hb1_o    <= nb1;
      hb2_o    <= nb2;
      hb3_o    <= nb3;
      vb1_o    <= nv1;
      vb2_o    <= nv2;
      vb3_o    <= nv3;
      vtot_o   <= nvt;
      hs_low_o <= cfg_pol[2];
      vs_low_o <= cfg_pol[1];
      mode_o   <= vmode_e'(cfg_mode);
    end
  end

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i)) |-> ($stable(hb3_o) && $stable(vtot_o) && $stable(hline_o) && $stable(mode_o)));
endmodule

// File: rtl/dvt_hcount.sv
module dvt_hcount
  import dvt_pkg::*;
#(
  parameter int HW = 12,
  parameter int BW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hline_i,
  input  logic [BW-1:0] hb1_i,
  input  logic [BW-1:0] hb2_i,
  input  logic [BW-1:0] hb3_i,
  output logic [HW-1:0] hcnt_o,
  output logic          line_end_o,
  output phase_e        phase_o
);
  logic [BW-1:0] hpos;

  assign hpos       = BW'(hcnt_o);
  assign line_end_o = ({1'b0, hcnt_o} + (HW+1)'(1)) >= {1'b0, hline_i};

  always_comb begin
    if (hpos < hb1_i)      phase_o = PH_SYNC;
    else if (hpos < hb2_i) phase_o = PH_BACK;
    else if (hpos < hb3_i) phase_o = PH_ACT;
    else                   phase_o = PH_FRONT;
  end

  always_ff @(posedge clk) begin
    if (rst || line_end_o) hcnt_o <= '0;
    else                   hcnt_o <= hcnt_o + HW'(1);
  end

  // R2
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hline_i != '0) |-> (hcnt_o < hline_i));
endmodule

// File: rtl/dvt_vcount.sv
module dvt_vcount
  import dvt_pkg::*;
#(
  parameter int VBW = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_end_i,
  input  logic [VBW-1:0] vb1_i,
  input  logic [VBW-1:0] vb2_i,
  input  logic [VBW-1:0] vb3_i,
  input  logic [VBW-1:0] vtot_i,
  output logic [VBW-1:0] vcnt_o,
  output logic           frame_wrap_o,
  output phase_e         phase_o
);
  logic last_line;

  assign last_line    = ({1'b0, vcnt_o} + (VBW+1)'(1)) >= {1'b0, vtot_i};
  assign frame_wrap_o = line_end_i && last_line;

  always_comb begin
    if (vcnt_o < vb1_i)      phase_o = PH_SYNC;
    else if (vcnt_o < vb2_i) phase_o = PH_BACK;
    else if (vcnt_o < vb3_i) phase_o = PH_ACT;
    else                     phase_o = PH_FRONT;
  end

  always_ff @(posedge clk) begin
    if (rst || frame_wrap_o) vcnt_o <= '0;
    else if (line_end_i)     vcnt_o <= vcnt_o + VBW'(1);
  end

  // R5
  vcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (vtot_i != '0) |-> (vcnt_o < vtot_i));
endmodule

// File: rtl/dsi_vid_timer.sv
module dsi_vid_timer
  import dvt_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] cfg_hsa,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hline,
  input  logic [SW-1:0] cfg_vsa,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfp,
  input  logic [PW-1:0] cfg_pkt_pix,
  input  logic [1:0]    cfg_lanes,
  input  logic [2:0]    cfg_pol,
  input  logic [1:0]    cfg_mode,
  output logic [1:0]    h_phase,
  output logic [1:0]    v_phase,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          hss_o,
  output logic          hse_o,
  output logic          vss_o,
  output logic          vse_o,
  output logic          frame_start_o
);
  localparam int BW  = ((HW > PW) ? HW : PW) + 3;
  localparam int VBW = VW + 2;

  logic [HW-1:0]  hline_q, hcnt;
  logic [BW-1:0]  hb1, hb2, hb3;
  logic [VBW-1:0] vb1, vb2, vb3, vtot, vcnt;
  logic           hs_low, vs_low, line_end, frame_wrap;
  vmode_e         mode_q;
  phase_e         hph, vph;

  dvt_cfg_shadow #(.HW(HW), .VW(VW), .PW(PW), .SW(SW)) shadow_i (
    .clk(clk), .rst(rst), .load_i(frame_wrap),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hline(cfg_hline),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .cfg_pkt_pix(cfg_pkt_pix), .cfg_lanes(cfg_lanes), .cfg_pol(cfg_pol), .cfg_mode(cfg_mode),
    .hline_o(hline_q), .hb1_o(hb1), .hb2_o(hb2), .hb3_o(hb3),
    .vb1_o(vb1), .vb2_o(vb2), .vb3_o(vb3), .vtot_o(vtot),
    .hs_low_o(hs_low), .vs_low_o(vs_low), .mode_o(mode_q)
  );

  dvt_hcount #(.HW(HW), .BW(BW)) hcount_i (
    .clk(clk), .rst(rst), .hline_i(hline_q),
    .hb1_i(hb1), .hb2_i(hb2), .hb3_i(hb3),
    .hcnt_o(hcnt), .line_end_o(line_end), .phase_o(hph)
  );

  dvt_vcount #(.VBW(VBW)) vcount_i (
    .clk(clk), .rst(rst), .line_end_i(line_end),
    .vb1_i(vb1), .vb2_i(vb2), .vb3_i(vb3), .vtot_i(vtot),
    .vcnt_o(vcnt), .frame_wrap_o(frame_wrap), .phase_o(vph)
  );

  logic line_first, frame_first, edge_marks;
  logic hse_n, vse_n;

  always_comb begin
    line_first  = (hcnt == '0);
    frame_first = line_first && (vcnt == '0);
    edge_marks  = (mode_q != VM_EVENT);
    hse_n = edge_marks && (hb1 != '0) && (BW'(hcnt) == hb1);
    vse_n = edge_marks && (vb1 != '0) && (vcnt == vb1) && line_first;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_phase       <= PH_SYNC;
      v_phase       <= PH_SYNC;
      hsync_o       <= cfg_pol[2];
      vsync_o       <= cfg_pol[1];
      de_o          <= 1'b0;
      hss_o         <= 1'b0;
      hse_o         <= 1'b0;
      vss_o         <= 1'b0;
      vse_o         <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      h_phase       <= hph;
      v_phase       <= vph;
      hsync_o       <= (hph == PH_SYNC) ^ hs_low;
      vsync_o       <= (vph == PH_SYNC) ^ vs_low;
      de_o          <= (hph == PH_ACT) && (vph == PH_ACT);
      hss_o         <= line_first;
      hse_o         <= hse_n;
      vss_o         <= frame_first && (vb1 != '0);
      vse_o         <= vse_n;
      frame_start_o <= frame_first;
    end
  end

  // R6
  de_phase_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (h_phase == PH_ACT && v_phase == PH_ACT));

  // R8
  event_no_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_q) == VM_EVENT) |-> (!hse_o && !vse_o));

  // R7
  vs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && v_phase != PH_SYNC) |-> (vsync_o == $past(vs_low)));

  // R2
  hss_first_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> hss_o);
endmodule

// File: tb/dsi_vid_timer_tb_top.sv
module dsi_vid_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 20000;

  typedef struct packed {
    logic [11:0] hsa, hbp, hline;
    logic [3:0]  vsa;
    logic [10:0] vbp, vact, vfp;
    logic [11:0] pix;
    logic [1:0]  lanes;
    logic [2:0]  pol;
    logic [1:0]  mode;
    logic [15:0] exp_frame, exp_de;
  } vec_t;

  // hsa hbp hline vsa vbp vact vfp pix lanes pol mode | frame de
  localparam vec_t VECS [6] = '{
    '{12'd4, 12'd3, 12'd30, 4'd2,  11'd1, 11'd3, 11'd2, 12'd8,  2'd3, 3'b000, 2'd0, 16'd240, 16'd18},
    '{12'd2, 12'd2, 12'd40, 4'd1,  11'd2, 11'd4, 11'd1, 12'd10, 2'd0, 3'b000, 2'd1, 16'd320, 16'd120},
    '{12'd3, 12'd1, 12'd20, 4'd3,  11'd0, 11'd2, 11'd1, 12'd5,  2'd1, 3'b110, 2'd2, 16'd120, 16'd16},
    '{12'd1, 12'd2, 12'd16, 4'd0,  11'd1, 11'd2, 11'd0, 12'd7,  2'd2, 3'b100, 2'd0, 16'd48,  16'd14},
    '{12'd5, 12'd5, 12'd14, 4'd1,  11'd1, 11'd2, 11'd1, 12'd4,  2'd0, 3'b000, 2'd0, 16'd70,  16'd8},
    '{12'd1, 12'd1, 12'd8,  4'd15, 11'd1, 11'd1, 11'd1, 12'd2,  2'd1, 3'b010, 2'd1, 16'd144, 16'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] cfg_hsa, cfg_hbp, cfg_hline, cfg_pkt_pix;
  logic [3:0]  cfg_vsa;
  logic [10:0] cfg_vbp, cfg_vact, cfg_vfp;
  logic [1:0]  cfg_lanes, cfg_mode;
  logic [2:0]  cfg_pol;
  logic [1:0]  h_phase, v_phase;
  logic hsync_o, vsync_o, de_o, hss_o, hse_o, vss_o, vse_o, frame_start_o;

  int errors = 0;
  int checks = 0;
  int n_cyc, n_de, n_hs, n_vs, n_hss, n_hse, n_vss, n_vse, first_de;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsi_vid_timer dut_i (
    .clk(clk), .rst(rst),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hline(cfg_hline),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .cfg_pkt_pix(cfg_pkt_pix), .cfg_lanes(cfg_lanes), .cfg_pol(cfg_pol), .cfg_mode(cfg_mode),
    .h_phase(h_phase), .v_phase(v_phase), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .hss_o(hss_o), .hse_o(hse_o), .vss_o(vss_o), .vse_o(vse_o),
    .frame_start_o(frame_start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cfg_hsa = v.hsa; cfg_hbp = v.hbp; cfg_hline = v.hline;
    cfg_vsa = v.vsa; cfg_vbp = v.vbp; cfg_vact = v.vact; cfg_vfp = v.vfp;
    cfg_pkt_pix = v.pix; cfg_lanes = v.lanes; cfg_pol = v.pol; cfg_mode = v.mode;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_fs();
    int n = 0;
    do begin @(negedge clk); n++; end while (!frame_start_o && n < LIMIT);
    if (n >= LIMIT) chk(1'b0, "watchdog", n, LIMIT);
  endtask

  // counts one frame starting at a negedge showing frame_start_o;
  // change_at >= 0 swaps the configuration to nv at that cycle
  task automatic run_frame(input logic hs_low, input logic vs_low,
                           input int change_at, input vec_t nv);
    int off = 0;
    n_cyc = 0; n_de = 0; n_hs = 0; n_vs = 0; n_hss = 0; n_hse = 0;
    n_vss = 0; n_vse = 0; first_de = -1;
    do begin
      if (hss_o) off = 0; else off++;
      if (de_o && first_de < 0) first_de = off;
      n_cyc++;
      if (de_o) n_de++;
      if (hsync_o != hs_low) n_hs++;
      if (vsync_o != vs_low) n_vs++;
      if (hss_o) n_hss++;
      if (hse_o) n_hse++;
      if (vss_o) n_vss++;
      if (vse_o) n_vse++;
      if (n_cyc == change_at) apply(nv);
      @(negedge clk);
    end while (!frame_start_o && n_cyc < LIMIT);
    if (n_cyc >= LIMIT) chk(1'b0, "watchdog", n_cyc, LIMIT);
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    apply(VECS[0]);
    cfg_pol = 3'b110;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(!de_o && !hss_o && !hse_o && !vss_o && !vse_o && !frame_start_o, "R1 idle", de_o, 0);
    chk(hsync_o == 1'b1, "R1 hsync level", hsync_o, 1);
    chk(vsync_o == 1'b1, "R1 vsync level", vsync_o, 1);
    apply(VECS[0]);
    do_reset();
    @(negedge clk);
    chk(frame_start_o == 1'b1, "R1 frame_start", frame_start_o, 1);
    chk(hss_o == 1'b1, "R1 hss", hss_o, 1);

    foreach (VECS[i]) begin
      vec_t v;
      int hl, vtot, act, act_eff, room;
      v = VECS[i];
      apply(v);
      do_reset();
      wait_fs();
      run_frame(v.pol[2], v.pol[1], -1, v);
      hl = (v.hline == 0) ? 1 : int'(v.hline);
      vtot = int'(v.vsa) + int'(v.vbp) + int'(v.vact) + int'(v.vfp);
      act = (3 * int'(v.pix) + int'(v.lanes)) / (int'(v.lanes) + 1);
      room = hl - int'(v.hsa) - int'(v.hbp);
      act_eff = (room < 0) ? 0 : min2(act, room);
      chk(n_cyc == int'(v.exp_frame), "R2 frame length", n_cyc, v.exp_frame);
      chk(n_cyc == hl * vtot, "R5 lines per frame", n_cyc, hl * vtot);
      chk(n_hss == vtot, "R2 hss per line", n_hss, vtot);
      // R4 R6 R10: enabled cycles per frame
      chk(n_de == int'(v.exp_de), "R4 R6 R10 de count", n_de, v.exp_de);
      chk(n_de == int'(v.vact) * act_eff, "R6 de formula", n_de, int'(v.vact) * act_eff);
      chk(first_de == int'(v.hsa) + int'(v.hbp), "R3 active offset", first_de, int'(v.hsa) + int'(v.hbp));
      // R3 R7: sync width at programmed polarity
      chk(n_hs == vtot * min2(int'(v.hsa), hl), "R3 R7 hsync cycles", n_hs, vtot * min2(int'(v.hsa), hl));
      chk(n_vs == int'(v.vsa) * hl, "R5 R7 vsync cycles", n_vs, int'(v.vsa) * hl);
      chk(n_vss == ((v.vsa != 0) ? 1 : 0), "R5 vss", n_vss, (v.vsa != 0) ? 1 : 0);
      chk(n_hse == ((v.mode != 2'd1 && v.hsa != 0 && int'(v.hsa) < hl) ? vtot : 0),
          "R8 hse", n_hse, (v.mode != 2'd1 && v.hsa != 0 && int'(v.hsa) < hl) ? vtot : 0);
      chk(n_vse == ((v.mode != 2'd1 && v.vsa != 0 && int'(v.vsa) < vtot) ? 1 : 0),
          "R8 vse", n_vse, (v.mode != 2'd1 && v.vsa != 0 && int'(v.vsa) < vtot) ? 1 : 0);
    end

    // R9: change mid-frame, current frame keeps old timing
    apply(VECS[0]);
    do_reset();
    wait_fs();
    run_frame(1'b0, 1'b0, 100, VECS[3]);
    chk(n_cyc == 240, "R9 current frame kept", n_cyc, 240);
    run_frame(1'b0, 1'b0, -1, VECS[3]);
    chk(n_cyc == 48, "R9 next frame updated", n_cyc, 48);
    chk(n_de == 14, "R9 next frame de", n_de, 14);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule